// File: doc/BRIEF.md
# SDRAM Command Bus Monitor and Bank State Tracker

This block listens to the command pins of a single-data-rate SDRAM interface: chip select, row strobe, column strobe, write enable, clock enable, bank address, address bus and the byte mask. It classifies the command sampled on each rising clock edge. It keeps an open or idle flag and the open row for each of four banks, and it holds the most recent mode op-code. It also flags commands that break the bank-state or mode-load rules. The memory array, the data path and analogue timing are outside the block.

It produces registered outputs: the decoded command, the per-bank open flags and rows, an auto-precharge strobe, byte-lane write and read enables derived from the mask, and a one-cycle violation pulse. Every output reflects the pins sampled at the previous rising edge. A controller or a test harness can use it to watch its own command stream.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: One cycle after the sampling edge, `cmd_o` shows the decoded command. The pins {cs_n,ras_n,cas_n,we_n} decode as follows: 0111 gives NOP (1), 0011 gives ACTIVE (2), 0101 gives READ (3), 0100 gives WRITE (4), 0110 gives BURST STOP (5), 0010 gives PRECHARGE (6) and 0000 gives LOAD MODE (9).
- R2: With cs_n high the command is INHIBIT (0) whatever the other pins hold. It changes no bank state and raises no violation.
- R3: Pins 0001 with cke high give AUTO REFRESH (7). With cke low they give SELF REFRESH (8). Any other executable command (not INHIBIT, not NOP) sampled with cke low raises `violation_o`.
- R4: ACTIVE to an idle bank opens the bank selected by `ba`. The bank's row output then holds addr[12:0] until a precharge closes it.
- R5: ACTIVE to a bank that is already open raises `violation_o` and leaves that bank's row unchanged.
- R6: READ or WRITE to an idle bank raises `violation_o`.
- R7: READ or WRITE with addr[10] high pulses `auto_pre_o` for one cycle. Its bank then goes idle at the AP_CYC-th edge after the command edge (4 by default).
- R8: PRECHARGE with addr[10] low closes only bank `ba`. With addr[10] high it closes all banks and ignores `ba`.
- R9: LOAD MODE latches addr[11:0] into `mode_o` only when all banks are idle. Otherwise it raises `violation_o` and `mode_o` keeps its value.
- R10: An executable command sampled fewer than MRD_CYC edges after an accepted LOAD MODE raises `violation_o` (MRD_CYC = 2).
- R11: `wr_en_o` is the inverted mask sampled at the same edge as the command. `rd_en_o` is that same value two cycles later.
- R12: While the synchronous active-high reset `rst` is high, all banks go idle, the mode-load wait clears, `violation_o` goes low and the enables clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | BA_W (2) | Bank address |
| addr | input | ADDR_W (13) | Row, column or op-code bus; bit 10 is the precharge qualifier |
| dqm | input | DQM_W (2) | Byte mask, high masks a lane |
| cmd_o | output | 4 | Decoded command code |
| bank_open_o | output | NUM_BANKS (4) | Per-bank open flag |
| bank_row_o | output | NUM_BANKS*ROW_W (52) | Open row per bank, bank i at bits [i*13 +: 13] |
| auto_pre_o | output | 1 | Access with auto precharge seen |
| mode_o | output | MODE_W (12) | Latched mode op-code |
| wr_en_o | output | DQM_W (2) | Write lane enables, zero-cycle mask alignment |
| rd_en_o | output | DQM_W (2) | Read lane enables, two-cycle mask alignment |
| violation_o | output | 1 | Protocol rule broken by the previous command |

## Verification
A table of commands runs one legal and one illegal form of each rule past the block. Reopening an open bank, accessing an idle bank and loading the mode while a bank is open each show up as a violation pulse, while the legal forms of the same commands do not. An inhibited activation sits next to the same activation with chip select low, which separates "ignored" from "executed". The same refresh pins with cke high and with cke low confirm the auto/self split. Directed runs sample the auto-precharge countdown on the edge before and the edge after the bank closes. Distinct per-lane mask patterns expose the zero-cycle and two-cycle enable alignment.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

    typedef enum logic [3:0] {
        CMD_INHIBIT   = 4'd0,
        CMD_NOP       = 4'd1,
        CMD_ACTIVE    = 4'd2,
        CMD_READ      = 4'd3,
        CMD_WRITE     = 4'd4,
        CMD_BSTOP     = 4'd5,
        CMD_PRECHARGE = 4'd6,
        CMD_AUTOREF   = 4'd7,
        CMD_SELFREF   = 4'd8,
        CMD_LOADMODE  = 4'd9
    } cmd_e;

    typedef struct packed {
        cmd_e kind;
        logic exec;
        logic cke_bad;
    } dec_t;

    // Bit of the address bus that carries the precharge qualifier
    localparam int QUAL_BIT = 10;
    // Read data mask alignment in cycles
    localparam int RD_LAT   = 2;

    function automatic cmd_e classify(input logic [3:0] pins, input logic cke);
        cmd_e c;
        case (pins)
            4'b0111: c = CMD_NOP;
            4'b0011: c = CMD_ACTIVE;
            4'b0101: c = CMD_READ;
            4'b0100: c = CMD_WRITE;
            4'b0110: c = CMD_BSTOP;
            4'b0010: c = CMD_PRECHARGE;
            4'b0001: c = cke ? CMD_AUTOREF : CMD_SELFREF;
            4'b0000: c = CMD_LOADMODE;
            default: c = CMD_INHIBIT;
        endcase
        return c;
    endfunction

    function automatic logic is_exec(input cmd_e c);
        return (c != CMD_INHIBIT) && (c != CMD_NOP);
    endfunction

    function automatic logic is_access(input cmd_e c);
        return (c == CMD_READ) || (c == CMD_WRITE);
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_mon_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic cke,
    output dec_t dec
);
    cmd_e kind;

    always_comb begin
        kind        = classify({cs_n, ras_n, cas_n, we_n}, cke);
        dec.kind    = kind;
        dec.exec    = is_exec(kind);
        // clock enable must be high except when entering self refresh
        dec.cke_bad = !cke && is_exec(kind) && (kind != CMD_SELFREF);
    end
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
    import sdram_mon_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BA_W      = 2,
    parameter int ROW_W     = 13,
    parameter int AP_CYC    = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  cmd_e                       kind,
    input  logic [BA_W-1:0]            bank,
    input  logic [ROW_W-1:0]           row,
    input  logic                       qual,
    output logic [NUM_BANKS-1:0]       open_o,
    output logic [NUM_BANKS*ROW_W-1:0] row_o,
    output logic                       reopen_viol,
    output logic                       idle_viol
);
    localparam int CNT_W = $clog2(AP_CYC + 1);

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        logic             open_q;
        logic [ROW_W-1:0] row_q;
        logic [CNT_W-1:0] ap_cnt;
        logic             hit;

        assign hit = (bank == BA_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                open_q <= 1'b0;
                row_q  <= '0;
                ap_cnt <= '0;
            end else if (kind == CMD_PRECHARGE && (qual || hit)) begin
                open_q <= 1'b0;
                ap_cnt <= '0;
            end else if (kind == CMD_ACTIVE && hit && !open_q) begin
                open_q <= 1'b1;
                row_q  <= row;
            end else if (is_access(kind) && hit && open_q && qual) begin
                ap_cnt <= CNT_W'(AP_CYC);
            end else if (ap_cnt == CNT_W'(1)) begin
                open_q <= 1'b0;
                ap_cnt <= '0;
            end else if (ap_cnt != '0) begin
                ap_cnt <= ap_cnt - CNT_W'(1);
            end
        end

        assign open_o[i]                = open_q;
        assign row_o[i*ROW_W +: ROW_W]  = row_q;
    end

    always_comb begin
        reopen_viol = (kind == CMD_ACTIVE) && open_o[bank];
        idle_viol   = is_access(kind) && !open_o[bank];
    end
endmodule

// File: rtl/sdram_mode_ctrl.sv
module sdram_mode_ctrl
    import sdram_mon_pkg::*;
#(
    parameter int MODE_W  = 12,
    parameter int MRD_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  dec_t              dec,
    input  logic [MODE_W-1:0] op,
    input  logic              any_open,
    output logic [MODE_W-1:0] mode_o,
    output logic              load_viol,
    output logic              early_viol
);
    localparam int CNT_W = $clog2(MRD_CYC + 1);

    logic [CNT_W-1:0] wait_cnt;

    always_comb begin
        load_viol  = (dec.kind == CMD_LOADMODE) && any_open;
        early_viol = dec.exec && (wait_cnt != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_o   <= '0;
            wait_cnt <= '0;
        end else if (dec.kind == CMD_LOADMODE && !any_open) begin
            mode_o   <= op;
            wait_cnt <= CNT_W'(MRD_CYC - 1);
        end else if (wait_cnt != '0) begin
            wait_cnt <= wait_cnt - CNT_W'(1);
        end
    end
endmodule

// File: rtl/sdram_dqm_pipe.sv
module sdram_dqm_pipe
    import sdram_mon_pkg::*;
#(
    parameter int DQM_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DQM_W-1:0] dqm,
    output logic [DQM_W-1:0] wr_en_o,
    output logic [DQM_W-1:0] rd_en_o
);
    logic [DQM_W-1:0] stg [RD_LAT+1];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= ~dqm;
    end

    for (genvar j = 1; j <= RD_LAT; j++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[j] <= '0;
            else     stg[j] <= stg[j-1];
        end
    end

    assign wr_en_o = stg[0];
    assign rd_en_o = stg[RD_LAT];
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
    import sdram_mon_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BA_W      = $clog2(NUM_BANKS),
    parameter int ADDR_W    = 13,
    parameter int ROW_W     = 13,
    parameter int MODE_W    = 12,
    parameter int DQM_W     = 2,
    parameter int MRD_CYC   = 2,
    parameter int AP_CYC    = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cs_n,
    input  logic                       ras_n,
    input  logic                       cas_n,
    input  logic                       we_n,
    input  logic                       cke,
    input  logic [BA_W-1:0]            ba,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DQM_W-1:0]           dqm,
    output logic [3:0]                 cmd_o,
    output logic [NUM_BANKS-1:0]       bank_open_o,
    output logic [NUM_BANKS*ROW_W-1:0] bank_row_o,
    output logic                       auto_pre_o,
    output logic [MODE_W-1:0]          mode_o,
    output logic [DQM_W-1:0]           wr_en_o,
    output logic [DQM_W-1:0]           rd_en_o,
    output logic                       violation_o
);
    dec_t dec;
    logic reopen_viol, idle_viol, load_viol, early_viol;
    logic qual;
    cmd_e cmd_q;
    logic ap_q, viol_q;

    assign qual = addr[QUAL_BIT];

    sdram_cmd_decode u_dec (
        .cs_n (cs_n),
        .ras_n(ras_n),
        .cas_n(cas_n),
        .we_n (we_n),
        .cke  (cke),
        .dec  (dec)
    );

    sdram_bank_tracker #(
        .NUM_BANKS(NUM_BANKS),
        .BA_W     (BA_W),
        .ROW_W    (ROW_W),
        .AP_CYC   (AP_CYC)
    ) u_banks (
        .clk        (clk),
        .rst        (rst),
        .kind       (dec.kind),
        .bank       (ba),
        .row        (addr[ROW_W-1:0]),
        .qual       (qual),
        .open_o     (bank_open_o),
        .row_o      (bank_row_o),
        .reopen_viol(reopen_viol),
        .idle_viol  (idle_viol)
    );

    sdram_mode_ctrl #(
        .MODE_W (MODE_W),
        .MRD_CYC(MRD_CYC)
    ) u_mode (
        .clk       (clk),
        .rst       (rst),
        .dec       (dec),
        .op        (addr[MODE_W-1:0]),
        .any_open  (|bank_open_o),
        .mode_o    (mode_o),
        .load_viol (load_viol),
        .early_viol(early_viol)
    );

    sdram_dqm_pipe #(
        .DQM_W(DQM_W)
    ) u_dqm (
        .clk    (clk),
        .rst    (rst),
        .dqm    (dqm),
        .wr_en_o(wr_en_o),
        .rd_en_o(rd_en_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= CMD_INHIBIT;
            ap_q   <= 1'b0;
            viol_q <= 1'b0;
        end else begin
            cmd_q  <= dec.kind;
            ap_q   <= is_access(dec.kind) && qual;
            viol_q <= dec.cke_bad | reopen_viol | idle_viol | load_viol | early_viol;
        end
    end

    assign cmd_o       = cmd_q;
    assign auto_pre_o  = ap_q;
    assign violation_o = viol_q;
endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk #(
    parameter int NUM_BANKS = 4,
    parameter int BA_W      = 2,
    parameter int ADDR_W    = 13,
    parameter int ROW_W     = 13,
    parameter int MODE_W    = 12,
    parameter int DQM_W     = 2
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       cs_n,
    input logic                       ras_n,
    input logic                       cas_n,
    input logic                       we_n,
    input logic                       cke,
    input logic [BA_W-1:0]            ba,
    input logic [ADDR_W-1:0]          addr,
    input logic [3:0]                 cmd_o,
    input logic [NUM_BANKS-1:0]       bank_open_o,
    input logic [NUM_BANKS*ROW_W-1:0] bank_row_o,
    input logic [MODE_W-1:0]          mode_o,
    input logic [DQM_W-1:0]           wr_en_o,
    input logic [DQM_W-1:0]           rd_en_o,
    input logic                       violation_o
);
    logic [3:0] pins;
    assign pins = {cs_n, ras_n, cas_n, we_n};

    // R2
    a_r2_inhibit_quiet: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (cmd_o == 4'd0 && !violation_o));

    // R5
    a_r5_reopen_flag: assert property (@(posedge clk) disable iff (rst)
        (pins == 4'b0011 && cke && bank_open_o[ba]) |=> (violation_o && $stable(bank_row_o)));

    // R6
    a_r6_idle_access: assert property (@(posedge clk) disable iff (rst)
        ((pins == 4'b0101 || pins == 4'b0100) && cke && !bank_open_o[ba]) |=> violation_o);

    // R8
    a_r8_close_all: assert property (@(posedge clk) disable iff (rst)
        (pins == 4'b0010 && cke && addr[10]) |=> (bank_open_o == '0));

    // R9
    a_r9_busy_load: assert property (@(posedge clk) disable iff (rst)
        (pins == 4'b0000 && cke && (|bank_open_o)) |=> (violation_o && $stable(mode_o)));

    // R11
    a_r11_read_lag: assert property (@(posedge clk) disable iff (rst)
        rd_en_o == $past(wr_en_o, 2));

    // R12
    a_r12_reset_clear: assert property (@(posedge clk)
        rst |=> (bank_open_o == '0 && !violation_o && wr_en_o == '0));
endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(
    .NUM_BANKS(NUM_BANKS),
    .BA_W     (BA_W),
    .ADDR_W   (ADDR_W),
    .ROW_W    (ROW_W),
    .MODE_W   (MODE_W),
    .DQM_W    (DQM_W)
) u_chk (.*);

// File: tb/sdram_cmd_monitor_test.sv
module sdram_cmd_monitor_test;
    localparam int NB = 4;
    localparam int RW = 13;

    logic clk = 1'b0;
    logic rst;
    logic cs_n, ras_n, cas_n, we_n, cke;
    logic [1:0]  ba;
    logic [12:0] addr;
    logic [1:0]  dqm;
    logic [3:0]  cmd_o;
    logic [NB-1:0] bank_open_o;
    logic [NB*RW-1:0] bank_row_o;
    logic auto_pre_o, violation_o;
    logic [11:0] mode_o;
    logic [1:0] wr_en_o, rd_en_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sdram_cmd_monitor uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cke(cke), .ba(ba), .addr(addr), .dqm(dqm), .cmd_o(cmd_o),
        .bank_open_o(bank_open_o), .bank_row_o(bank_row_o), .auto_pre_o(auto_pre_o),
        .mode_o(mode_o), .wr_en_o(wr_en_o), .rd_en_o(rd_en_o), .violation_o(violation_o)
    );

    // {pins[4], cke, ba[2], addr[13], cmd[4], viol, open[4]}
    localparam logic [28:0] VEC [18] = '{
        {4'b0000, 1'b1, 2'd0, 13'h0023, 4'd9, 1'b0, 4'b0000},
        {4'b0111, 1'b1, 2'd0, 13'h0000, 4'd1, 1'b0, 4'b0000},
        {4'b0011, 1'b1, 2'd1, 13'h1ABC, 4'd2, 1'b0, 4'b0010},
        {4'b0011, 1'b1, 2'd1, 13'h0005, 4'd2, 1'b1, 4'b0010},
        {4'b0101, 1'b1, 2'd2, 13'h0000, 4'd3, 1'b1, 4'b0010},
        {4'b0100, 1'b1, 2'd1, 13'h0010, 4'd4, 1'b0, 4'b0010},
        {4'b0011, 1'b1, 2'd3, 13'h0077, 4'd2, 1'b0, 4'b1010},
        {4'b0010, 1'b1, 2'd1, 13'h0000, 4'd6, 1'b0, 4'b1000},
        {4'b1011, 1'b1, 2'd0, 13'h0000, 4'd0, 1'b0, 4'b1000},
        {4'b0110, 1'b1, 2'd0, 13'h0000, 4'd5, 1'b0, 4'b1000},
        {4'b0001, 1'b1, 2'd0, 13'h0000, 4'd7, 1'b0, 4'b1000},
        {4'b0010, 1'b1, 2'd1, 13'h0400, 4'd6, 1'b0, 4'b0000},
        {4'b0000, 1'b1, 2'd0, 13'h0031, 4'd9, 1'b0, 4'b0000},
        {4'b0011, 1'b1, 2'd0, 13'h0100, 4'd2, 1'b1, 4'b0001},
        {4'b0000, 1'b1, 2'd0, 13'h0FFF, 4'd9, 1'b1, 4'b0001},
        {4'b0111, 1'b1, 2'd0, 13'h0000, 4'd1, 1'b0, 4'b0001},
        {4'b0001, 1'b0, 2'd0, 13'h0000, 4'd8, 1'b0, 4'b0001},
        {4'b0101, 1'b0, 2'd0, 13'h0000, 4'd3, 1'b1, 4'b0001}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one command at the falling edge, sample just after the next rising edge
    task automatic step(input logic [3:0] p, input logic ck, input logic [1:0] b,
                        input logic [12:0] a);
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = p;
        cke  = ck;
        ba   = b;
        addr = a;
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        {cs_n, ras_n, cas_n, we_n} = 4'b0111;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        {cs_n, ras_n, cas_n, we_n} = 4'b0111;
        cke = 1'b1; ba = '0; addr = '0; dqm = 2'b11;
        do_reset();
        #2;
        // R12 reset state
        chk("R12 reset open", 32'(bank_open_o), 32'd0);
        chk("R12 reset violation", 32'(violation_o), 32'd0);
        chk("R12 reset cmd", 32'(cmd_o), 32'd0);
        chk("R12 reset enables", 32'({wr_en_o, rd_en_o}), 32'd0);

        // table walk: R1 R2 R3 R4 R5 R6 R8 R9 R10
        foreach (VEC[i]) begin
            step(VEC[i][28:25], VEC[i][24], VEC[i][23:22], VEC[i][21:9]);
            chk($sformatf("R1 table %0d cmd", i), 32'(cmd_o), 32'(VEC[i][8:5]));
            chk($sformatf("R3 R5 R6 R9 R10 table %0d violation", i), 32'(violation_o),
                32'(VEC[i][4]));
            chk($sformatf("R2 R4 R8 table %0d open", i), 32'(bank_open_o), 32'(VEC[i][3:0]));
        end
        chk("R9 mode kept after refused load", 32'(mode_o), 32'h031);

        // R4 R7 auto precharge countdown
        do_reset();
        step(4'b0011, 1'b1, 2'd2, 13'h1234);
        chk("R4 row latched", 32'(bank_row_o[2*RW +: RW]), 32'h1234);
        step(4'b0101, 1'b1, 2'd2, 13'h0400);
        chk("R7 auto_pre pulse", 32'(auto_pre_o), 32'd1);
        chk("R7 still open at edge k", 32'(bank_open_o[2]), 32'd1);
        step(4'b0111, 1'b1, 2'd0, 13'h0000);
        chk("R7 auto_pre one cycle", 32'(auto_pre_o), 32'd0);
        step(4'b0111, 1'b1, 2'd0, 13'h0000);
        step(4'b0111, 1'b1, 2'd0, 13'h0000);
        chk("R7 open at edge k+3", 32'(bank_open_o[2]), 32'd1);
        step(4'b0111, 1'b1, 2'd0, 13'h0000);
        chk("R7 idle at edge k+4", 32'(bank_open_o[2]), 32'd0);

        // R4 R5 reopen after auto close, then illegal reopen keeps row
        step(4'b0011, 1'b1, 2'd2, 13'h0555);
        chk("R4 reopen legal", 32'(violation_o), 32'd0);
        chk("R4 new row", 32'(bank_row_o[2*RW +: RW]), 32'h0555);
        step(4'b0011, 1'b1, 2'd2, 13'h0AAA);
        chk("R5 reopen flagged", 32'(violation_o), 32'd1);
        chk("R5 row kept", 32'(bank_row_o[2*RW +: RW]), 32'h0555);

        // R8 single-bank precharge leaves others open
        step(4'b0011, 1'b1, 2'd0, 13'h0001);
        step(4'b0010, 1'b1, 2'd2, 13'h0000);
        chk("R8 single precharge", 32'(bank_open_o), 32'b0001);

        // R11 mask alignment
        do_reset();
        @(negedge clk); dqm = 2'b01; @(posedge clk); #2;
        chk("R11 write enable zero delay", 32'(wr_en_o), 32'b10);
        @(negedge clk); dqm = 2'b11; @(posedge clk); #2;
        chk("R11 write masked", 32'(wr_en_o), 32'b00);
        @(negedge clk); dqm = 2'b00; @(posedge clk); #2;
        chk("R11 read enable two cycles", 32'(rd_en_o), 32'b10);
        @(negedge clk); @(posedge clk); #2;
        chk("R11 read masked", 32'(rd_en_o), 32'b00);

        // R12 reset wins over an illegal command
        step(4'b0011, 1'b1, 2'd1, 13'h0002);
        @(negedge clk);
        rst = 1'b1;
        {cs_n, ras_n, cas_n, we_n} = 4'b0011;
        @(posedge clk); #2;
        chk("R12 reset clears violation", 32'(violation_o), 32'd0);
        chk("R12 reset idles banks", 32'(bank_open_o), 32'd0);
        @(negedge clk);
        rst = 1'b0;
        {cs_n, ras_n, cas_n, we_n} = 4'b0111;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule